// File: doc/BRIEF.md
# Converter Mode-Control Port Decoder

This block turns four slow control pins into the settings word that an audio converter's filter path consumes: a speed select (normal or double rate), a de-emphasis enable, a soft-mute request and an 8-bit attenuation code. A mode-select pin picks one of two schemes for the other three pins, which are shared. In serial scheme a three-wire port (data, shift clock, latch) loads a ten-bit control word. In parallel scheme the same three pins drive the speed, de-emphasis and mute bits directly, and the attenuation code stays frozen.

All pins pass through two-flop synchronisers. A state machine tracks the scheme and the latch handshake. Its states are `S_PAR` (parallel scheme), `S_SER_IDLE` (serial, latch pin at rest high, shifting allowed), `S_SER_ARMED` (latch pin seen falling, waiting for it to rise) and `S_SER_COMMIT` (one cycle in which the shifted word is applied). The transitions are: any state to `S_PAR` when the synchronised mode pin is high; `S_PAR` to `S_SER_IDLE` when it is low; `S_SER_IDLE` to `S_SER_ARMED` on a falling latch edge; `S_SER_ARMED` to `S_SER_COMMIT` on a rising latch edge; and `S_SER_COMMIT` to `S_SER_IDLE` unconditionally.

Top module: `dac_ctrl_port`

## Requirements
- R1: After reset (active-low `rst_n`) the outputs are `dbl_speed`=0, `deemph_on`=0, `mute_req`=0, `atten_code`=8'h7F (0 dB) and `atten_upd`=0.
- R2: In serial scheme (`mode_sel`=0) each rising edge of `sh_emph` samples `dat_mute` into a ten-bit word, the first bit sampled being bit 0. On a latch, bit 0 drives `dbl_speed` (1 = double), bit 1 drives `deemph_on` (1 = on), and bits 9..2 become `atten_code` with bit 9 as its MSB.
- R3: If bit 9 of the word is 1 at a latch, `atten_code` keeps its previous value while `dbl_speed` and `deemph_on` still update.
- R4: `atten_upd` pulses high for exactly one clock per latch whose bit 9 is 0, and stays low for a latch whose bit 9 is 1.
- R5: A latch needs `lat_spd` to go low and then return high; the word is applied on the return to high. Shift edges with no latch leave every output unchanged.
- R6: In parallel scheme (`mode_sel`=1) `dbl_speed` follows `lat_spd`, `deemph_on` follows `sh_emph` and `mute_req` follows `dat_mute` (1 = mute).
- R7: In parallel scheme `atten_code` does not change and `atten_upd` never pulses, whatever the three pins do.
- R8: In serial scheme `mute_req` is 0.
- R9: On return from parallel to serial scheme the outputs again show the values of the last serial latch.
- R10: When more than ten bits are shifted before a latch, only the last ten shifted count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 1 | Scheme select: 0 serial, 1 parallel |
| sh_emph | input | 1 | Serial shift clock / parallel de-emphasis |
| lat_spd | input | 1 | Serial latch (rests high) / parallel speed |
| dat_mute | input | 1 | Serial data / parallel mute request |
| dbl_speed | output | 1 | 1 = double-speed input rate |
| deemph_on | output | 1 | 1 = de-emphasis enabled |
| mute_req | output | 1 | 1 = soft mute requested |
| atten_code | output | 8 | Attenuation code, 8'h7F = 0 dB |
| atten_upd | output | 1 | One-cycle strobe when the attenuation code is loaded |

## Verification
The serial path is tried with a sequence of words that alternate the two flag bits and mix clear and set sentinel bits, so that a design that ignores the sentinel, applies it to the flags too, or swaps bit order gives a different attenuation or flag value. An over-long shift tells a right-aligned last-ten-bits register from one that keeps the first ten, and a shift burst with no latch tells a latch-gated commit from one that applies on every shift. Parallel patterns walk the three pins through distinct combinations so each pin-to-output mapping is separately visible, while latch-like pulses there show that neither the attenuation nor the strobe moves; switching back to serial shows that the stored serial settings survived.

// File: rtl/dcif_pkg.sv
package dcif_pkg;

    localparam int ATT_W    = 8;
    localparam int WORD_W   = ATT_W + 2;
    localparam int NUM_PINS = 4;

    // Pin vector positions
    localparam int P_MODE  = 0;
    localparam int P_SHIFT = 1;
    localparam int P_LATCH = 2;
    localparam int P_DATA  = 3;

    // Rest values of the pins at reset: latch pin idles high
    localparam logic [NUM_PINS-1:0] PIN_REST = 4'b0100;

    // Word field positions
    localparam int F_SPD  = 0;
    localparam int F_EMP  = 1;
    localparam int F_ATTL = 2;
    localparam int F_SENT = WORD_W - 1;

    typedef enum logic [1:0] {
        S_PAR        = 2'd0,
        S_SER_IDLE   = 2'd1,
        S_SER_ARMED  = 2'd2,
        S_SER_COMMIT = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/dcif_sync.sv
module dcif_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], pin_i[b]};
            end
        end
        assign lvl_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/dcif_serial_fsm.sv
module dcif_serial_fsm
    import dcif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_lvl,
    input  logic             shift_lvl,
    input  logic             latch_lvl,
    input  logic             data_lvl,
    output ctl_state_e       state_o,
    output logic             spd_o,
    output logic             emp_o,
    output logic [ATT_W-1:0] att_o,
    output logic             upd_o
);

    localparam logic [WORD_W-1:0] WORD_RST  = {1'b0, {(ATT_W-1){1'b1}}, 2'b00};
    localparam logic [ATT_W-1:0]  ATT_RST   = {1'b0, {(ATT_W-1){1'b1}}};

    ctl_state_e        state_q, state_d;
    logic              shift_prev, latch_prev;
    logic              shift_rise, latch_rise, latch_fall;
    logic [WORD_W-1:0] word_q;

    // Edge detection on synchronised levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_prev <= PIN_REST[P_SHIFT];
            latch_prev <= PIN_REST[P_LATCH];
        end else begin
            shift_prev <= shift_lvl;
            latch_prev <= latch_lvl;
        end
    end

    assign shift_rise = shift_lvl & ~shift_prev;
    assign latch_rise = latch_lvl & ~latch_prev;
    assign latch_fall = ~latch_lvl & latch_prev;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_SER_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (mode_lvl) begin
            state_d = S_PAR;
        end else begin
            unique case (state_q)
                S_PAR:        state_d = S_SER_IDLE;
                S_SER_IDLE:   if (latch_fall) state_d = S_SER_ARMED;
                S_SER_ARMED:  if (latch_rise) state_d = S_SER_COMMIT;
                S_SER_COMMIT: state_d = S_SER_IDLE;
                default:      state_d = S_SER_IDLE;
            endcase
        end
    end

    // Shift register: newest bit enters at the top, first bit ends in bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= WORD_RST;
        end else if (state_q == S_SER_IDLE && !mode_lvl && shift_rise) begin
            word_q <= {data_lvl, word_q[WORD_W-1:1]};
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spd_o <= 1'b0;
            emp_o <= 1'b0;
            att_o <= ATT_RST;
            upd_o <= 1'b0;
        end else begin
            upd_o <= 1'b0;
            unique case (state_q)
                S_SER_COMMIT: begin
                    spd_o <= word_q[F_SPD];
                    emp_o <= word_q[F_EMP];
                    if (!word_q[F_SENT]) begin
                        att_o <= word_q[F_SENT:F_ATTL];
                        upd_o <= 1'b1;
                    end
                end
                S_PAR, S_SER_IDLE, S_SER_ARMED: ;
                default: ;
            endcase
        end
    end

    assign state_o = state_q;

    // R4: strobe never lasts longer than one cycle
    a_r4_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    // R3 / R7: attenuation only moves together with the strobe
    a_r3_att_moves_with_upd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(att_o) |-> upd_o);

    // R5: commit only follows the armed state
    a_r5_commit_after_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SER_COMMIT) |-> ($past(state_q) == S_SER_ARMED));

    // R5: arming requires a falling latch edge
    a_r5_arm_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SER_ARMED && $past(state_q) != S_SER_ARMED) |-> $past(latch_fall));

endmodule

// File: rtl/dcif_out_sel.sv
module dcif_out_sel
    import dcif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_state_e       state_i,
    input  logic             shift_lvl,
    input  logic             latch_lvl,
    input  logic             data_lvl,
    input  logic             spd_i,
    input  logic             emp_i,
    input  logic             upd_i,
    output logic             spd_o,
    output logic             emp_o,
    output logic             mute_o
);

    logic par_sel;
    assign par_sel = (state_i == S_PAR);

    always_comb begin
        if (par_sel) begin
            spd_o  = latch_lvl;
            emp_o  = shift_lvl;
            mute_o = data_lvl;
        end else begin
            spd_o  = spd_i;
            emp_o  = emp_i;
            mute_o = 1'b0;
        end
    end

    // R7: no strobe while parallel scheme persists
    a_r7_no_upd_in_par: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && $past(state_i) == S_PAR) |-> !upd_i);

    // R9: stored flags are untouched while in parallel scheme
    a_r9_flags_held_in_par: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && $past(state_i) == S_PAR) |-> ($stable(spd_i) && $stable(emp_i)));

endmodule

// File: rtl/dac_ctrl_port.sv
module dac_ctrl_port
    import dcif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             sh_emph,
    input  logic             lat_spd,
    input  logic             dat_mute,
    output logic             dbl_speed,
    output logic             deemph_on,
    output logic             mute_req,
    output logic [ATT_W-1:0] atten_code,
    output logic             atten_upd
);

    logic [NUM_PINS-1:0] pins_raw, pins_s;
    ctl_state_e          state;
    logic                spd_ser, emp_ser, upd_ser;
    logic [ATT_W-1:0]    att_ser;

    always_comb begin
        pins_raw          = '0;
        pins_raw[P_MODE]  = mode_sel;
        pins_raw[P_SHIFT] = sh_emph;
        pins_raw[P_LATCH] = lat_spd;
        pins_raw[P_DATA]  = dat_mute;
    end

    dcif_sync #(
        .W       (NUM_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_REST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pins_raw),
        .lvl_o (pins_s)
    );

    dcif_serial_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_lvl  (pins_s[P_MODE]),
        .shift_lvl (pins_s[P_SHIFT]),
        .latch_lvl (pins_s[P_LATCH]),
        .data_lvl  (pins_s[P_DATA]),
        .state_o   (state),
        .spd_o     (spd_ser),
        .emp_o     (emp_ser),
        .att_o     (att_ser),
        .upd_o     (upd_ser)
    );

    dcif_out_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state),
        .shift_lvl (pins_s[P_SHIFT]),
        .latch_lvl (pins_s[P_LATCH]),
        .data_lvl  (pins_s[P_DATA]),
        .spd_i     (spd_ser),
        .emp_i     (emp_ser),
        .upd_i     (upd_ser),
        .spd_o     (dbl_speed),
        .emp_o     (deemph_on),
        .mute_o    (mute_req)
    );

    assign atten_code = att_ser;
    assign atten_upd  = upd_ser;

    // R8: serial scheme never requests mute
    a_r8_no_mute_serial: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_PAR) |-> !mute_req);

endmodule

// File: tb/dac_ctrl_port_bench.sv
module dac_ctrl_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic       sh_emph = 1'b0;
    logic       lat_spd = 1'b1;
    logic       dat_mute = 1'b0;
    logic       dbl_speed, deemph_on, mute_req, atten_upd;
    logic [7:0] atten_code;

    int checks = 0;
    int fails = 0;
    int upd_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dac_ctrl_port u_dac_ctrl_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .sh_emph    (sh_emph),
        .lat_spd    (lat_spd),
        .dat_mute   (dat_mute),
        .dbl_speed  (dbl_speed),
        .deemph_on  (deemph_on),
        .mute_req   (mute_req),
        .atten_code (atten_code),
        .atten_upd  (atten_upd)
    );

    always @(posedge clk) if (rst_n && atten_upd) upd_cnt <= upd_cnt + 1;

    // fields: word[9:0], dbl, emp, att[7:0], upd pulses
    localparam logic [20:0] VEC [0:4] = '{
        {8'h40, 1'b0, 1'b1, 1'b1, 1'b0, 8'h40, 1'b1},
        {8'h85, 1'b1, 1'b0, 1'b0, 1'b1, 8'h40, 1'b0},
        {8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1},
        {8'h7F, 1'b0, 1'b0, 1'b0, 1'b0, 8'h7F, 1'b1},
        {8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 8'h7F, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            dat_mute = bits[i];
            cyc(3);
            sh_emph = 1'b1;
            cyc(3);
            sh_emph = 1'b0;
            cyc(3);
        end
        dat_mute = 1'b0;
    endtask

    task automatic pulse_latch();
        lat_spd = 1'b0;
        cyc(4);
        lat_spd = 1'b1;
        cyc(6);
    endtask

    task automatic chk_all(input string tag, input logic d, input logic e,
                           input logic m, input logic [7:0] a);
        chk({tag, " dbl_speed"}, dbl_speed, d);
        chk({tag, " deemph_on"}, deemph_on, e);
        chk({tag, " mute_req"}, mute_req, m);
        chk({tag, " atten_code"}, atten_code, a);
    endtask

    initial begin
        int base;
        cyc(3);
        // R1 reset defaults
        chk_all("R1 in reset", 1'b0, 1'b0, 1'b0, 8'h7F);
        chk("R1 upd in reset", atten_upd, 1'b0);
        rst_n = 1'b1;
        cyc(5);
        chk_all("R1 after reset", 1'b0, 1'b0, 1'b0, 8'h7F);
        chk("R1 no strobe", upd_cnt, 0);

        // R2 R3 R4 R8: vector table
        for (int v = 0; v < 5; v++) begin
            base = upd_cnt;
            send_bits({6'b0, VEC[v][20:11]}, 10);
            pulse_latch();
            chk_all($sformatf("R2 R3 R8 vec%0d", v), VEC[v][10], VEC[v][9], 1'b0, VEC[v][8:1]);
            chk($sformatf("R4 vec%0d strobe count", v), upd_cnt - base, VEC[v][0]);
        end

        // R10: twelve bits, last ten count (word = att 2A, emp 1, spd 0)
        base = upd_cnt;
        send_bits({4'b0, 8'h2A, 1'b1, 1'b0, 2'b11}, 12);
        pulse_latch();
        chk_all("R10 long shift", 1'b0, 1'b1, 1'b0, 8'h2A);
        chk("R10 strobe", upd_cnt - base, 1);

        // R5: shifts without latch change nothing
        base = upd_cnt;
        send_bits(16'h001F, 5);
        cyc(4);
        chk_all("R5 no latch", 1'b0, 1'b1, 1'b0, 8'h2A);
        chk("R5 no strobe", upd_cnt - base, 0);

        // R6 R7: parallel scheme
        base = upd_cnt;
        mode_sel = 1'b1;
        cyc(5);
        for (int p = 0; p < 8; p++) begin
            lat_spd  = p[0];
            sh_emph  = p[1];
            dat_mute = p[2];
            cyc(5);
            chk_all($sformatf("R6 R7 pins%0d", p), p[0], p[1], p[2], 8'h2A);
        end
        lat_spd = 1'b1; cyc(4); lat_spd = 1'b0; cyc(4); lat_spd = 1'b1; cyc(5);
        chk("R7 atten frozen", atten_code, 8'h2A);
        chk("R7 no strobe", upd_cnt - base, 0);

        // R9: back to serial, stored values return
        sh_emph = 1'b0; dat_mute = 1'b0; lat_spd = 1'b1;
        cyc(4);
        mode_sel = 1'b0;
        cyc(6);
        chk_all("R9 serial restored", 1'b0, 1'b1, 1'b0, 8'h2A);

        // R1: reset again restores defaults
        rst_n = 1'b0;
        cyc(3);
        chk_all("R1 re-reset", 1'b0, 1'b0, 1'b0, 8'h7F);
        rst_n = 1'b1;
        cyc(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule